// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

A watchdog peripheral on a simple 32-bit register bus. Software enables it once. From then on a down-counter runs on every clock. Software must restart the counter before it reaches zero, and it can do so only by writing a fixed key value. If the count runs out, the block responds in one of two ways. In the direct mode it drives a system reset pulse at once. In the two-stage mode it first raises an interrupt and reloads. A reset pulse follows only if the next period also runs out while that interrupt is still pending.

The timeout period comes from a 4-bit select value `t` and lasts 2^(BASE_EXP+t) clocks. The counter is loaded with that period minus one. Two separate selects exist. One is used only for the load that follows enable. The other is used for every later reload. The reset pulse lasts 2^(n+1) clocks, where `n` is a 3-bit code, so it can be 2 to 256 clocks long. Software can read the live count and the interrupt status. It clears the interrupt by reading an acknowledge register.

The bus uses byte offsets. 0x00 is control, 0x04 holds the timeout selects, 0x08 is the live count, 0x0C is the restart key, 0x10 is status and 0x14 is the acknowledge register. An access takes place in any cycle with `bus_sel` high. Read data is registered and appears in the cycle after the access.

Top module: `wdog_keyed`

## Requirements
- R1: After synchronous reset, every register reads 0 and both `wdt_irq` and `wdt_rst_out` are low.
- R2: Control bit 0 enables the watchdog. Once it is set, a write of 0 does not clear it, and control still reads back with bit 0 set. Only reset clears it.
- R3: In the cycle after enable, the counter loads 2^(BASE_EXP+t_init)-1, where t_init is timeout register bits 7:4.
- R4: While running and not restarted, the count at 0x08 drops by one every clock.
- R5: A write to 0x0C whose low 8 bits equal 0x76 reloads the counter with 2^(BASE_EXP+t_run)-1, where t_run is timeout register bits 3:0. The same write clears a pending interrupt. A write with any other low byte changes nothing.
- R6: With control bit 1 at 0, an expiry starts the reset pulse in the clock after the count reaches 0, and the interrupt never rises.
- R7: With control bit 1 at 1, an expiry with no interrupt pending sets the interrupt and reloads the counter. An expiry while the interrupt is pending starts the reset pulse instead.
- R8: The reset pulse stays high for exactly 2^(n+1) clocks, where n is control bits 4:2.
- R9: Status bit 0 shows the pending interrupt. A read of 0x14 clears the interrupt and leaves the count running undisturbed.
- R10: The interrupt is cleared when a reset pulse starts. One clock after the pulse ends, the counter reloads with the running period.
- R11: A write to the timeout register in the middle of a count leaves the current count alone. The new value applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per cycle when high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| wdt_irq | output | 1 | Pending first-stage interrupt |
| wdt_rst_out | output | 1 | System reset pulse |

## Verification
The bench checks how many cycles pass from enable to expiry. A design that loaded the running select on the first load, or that counted one period too many or too few, would move that edge. Several corner cases get their own checks:
- A key value with extra upper bits set must still restart the counter. A design that compared the whole word would miss that restart.
- A near-miss key value must leave the count alone.
- The acknowledge read must clear the interrupt without reloading the counter. The next expiry must then raise the interrupt again and must not reset.
- The pulse length is measured at codes 0, 3 and 7. An off-by-one in the pulse counter, or an overflow at the 256-clock code, shows up as a wrong length.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int WCODE_W = 3;
  localparam int SEL_W   = 4;
  localparam logic [7:0] KICK_KEY = 8'h76;

  typedef enum logic [2:0] {
    RI_CTRL  = 3'd0,
    RI_RANGE = 3'd1,
    RI_COUNT = 3'd2,
    RI_KICK  = 3'd3,
    RI_STAT  = 3'd4,
    RI_ACK   = 3'd5
  } reg_idx_e;

  typedef enum logic [1:0] {
    WD_IDLE,
    WD_RUN,
    WD_HOLD
  } wd_state_e;

  typedef struct packed {
    logic [WCODE_W-1:0] width;
    logic               mode;
    logic               en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_i,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl_o,
  output logic [SEL_W-1:0]  run_sel_o,
  output logic [SEL_W-1:0]  init_sel_o,
  output logic              kick_o,
  output logic              ack_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   idx;
  logic               wr_hit, rd_hit;
  logic [2*SEL_W-1:0] range_q;
  logic [DATA_W-1:0]  rd_mux;
  wire unused_bits = &{1'b0, wdata[DATA_W-1:8], addr[1:0]};

  assign idx    = addr[ADDR_W-1:2];
  assign wr_hit = sel & wr;
  assign rd_hit = sel & ~wr;

  assign run_sel_o  = range_q[SEL_W-1:0];
  assign init_sel_o = range_q[2*SEL_W-1:SEL_W];
  assign kick_o = wr_hit && (idx == IDX_W'(RI_KICK)) && (wdata[7:0] == KICK_KEY);
  assign ack_o  = rd_hit && (idx == IDX_W'(RI_ACK));

  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_W'(RI_CTRL):  rd_mux = DATA_W'(ctrl_o);
      IDX_W'(RI_RANGE): rd_mux = DATA_W'(range_q);
      IDX_W'(RI_COUNT): rd_mux = DATA_W'(cnt_i);
      IDX_W'(RI_STAT):  rd_mux = DATA_W'(irq_i);
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o  <= '0;
      range_q <= '0;
      rdata   <= '0;
    end else begin
      if (wr_hit && idx == IDX_W'(RI_CTRL)) begin
        ctrl_o.en    <= ctrl_o.en | wdata[0];
        ctrl_o.mode  <= wdata[1];
        ctrl_o.width <= wdata[2 +: WCODE_W];
      end
      if (wr_hit && idx == IDX_W'(RI_RANGE))
        range_q <= wdata[2*SEL_W-1:0];
      if (rd_hit)
        rdata <= rd_mux;
    end
  end

  p_enable_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_o.en) |-> ctrl_o.en);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mode,
  input  logic [SEL_W-1:0] run_sel,
  input  logic [SEL_W-1:0] init_sel,
  input  logic             kick,
  input  logic             ack,
  input  logic             pulse_busy,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             fire_o
);
  wd_state_e        st;
  logic [CNT_W-1:0] run_top, init_top;
  logic             expire;

  function automatic logic [CNT_W-1:0] top_of(input logic [SEL_W-1:0] s);
    return (CNT_W'(1) << (BASE_EXP + int'(s))) - CNT_W'(1);
  endfunction

  assign run_top  = top_of(run_sel);
  assign init_top = top_of(init_sel);
  assign expire   = (st == WD_RUN) && (cnt_o == '0) && !kick;
  assign fire_o   = expire && (!mode || irq_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= WD_IDLE;
      cnt_o <= '0;
      irq_o <= 1'b0;
    end else begin
      case (st)
        WD_IDLE: if (en) begin
          cnt_o <= init_top;
          st    <= WD_RUN;
        end
        WD_RUN: begin
          if (kick) begin
            cnt_o <= run_top;
            irq_o <= 1'b0;
          end else if (cnt_o == '0) begin
            if (fire_o) begin
              st    <= WD_HOLD;
              irq_o <= 1'b0;
            end else begin
              irq_o <= 1'b1;
              cnt_o <= run_top;
            end
          end else begin
            cnt_o <= cnt_o - CNT_W'(1);
            if (ack) irq_o <= 1'b0;
          end
        end
        WD_HOLD: if (!pulse_busy) begin
          cnt_o <= run_top;
          st    <= WD_RUN;
        end
        default: st <= WD_IDLE;
      endcase
    end
  end

  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (st == WD_RUN && cnt_o != '0 && !kick) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));
  p_kick_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (st == WD_RUN && kick) |=> (cnt_o == $past(run_top) && !irq_o));
  p_irq_mode_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(mode));
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (ack && st == WD_RUN && cnt_o != '0) |=> !irq_o);
  p_irq_low_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (st == WD_HOLD) |-> !irq_o);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int WCODE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WCODE_W-1:0] code,
  output logic               busy
);
  localparam int LEFT_W = 1 << WCODE_W;

  logic [LEFT_W-1:0] left;
  logic [LEFT_W:0]   span;

  assign span = (LEFT_W+1)'(1) << (int'(code) + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      left <= LEFT_W'(span - (LEFT_W+1)'(1));
    end else if (busy) begin
      if (left == '0) busy <= 1'b0;
      else            left <= left - LEFT_W'(1);
    end
  end

  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst_out
);
  ctrl_t            ctrl;
  logic [SEL_W-1:0] run_sel, init_sel;
  logic             kick, ack, fire;
  logic [CNT_W-1:0] cnt;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cnt_i(cnt), .irq_i(wdt_irq), .rdata(bus_rdata),
    .ctrl_o(ctrl), .run_sel_o(run_sel), .init_sel_o(init_sel),
    .kick_o(kick), .ack_o(ack)
  );

  wdog_counter #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP)) u_cnt (
    .clk(clk), .rst(rst), .en(ctrl.en), .mode(ctrl.mode),
    .run_sel(run_sel), .init_sel(init_sel), .kick(kick), .ack(ack),
    .pulse_busy(wdt_rst_out), .cnt_o(cnt), .irq_o(wdt_irq), .fire_o(fire)
  );

  wdog_pulse #(.WCODE_W(WCODE_W)) u_pulse (
    .clk(clk), .rst(rst), .start(fire), .code(ctrl.width), .busy(wdt_rst_out)
  );
endmodule

// File: tb/test_wdog_keyed.sv
module test_wdog_keyed;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_irq, wdt_rst_out;

  int checks = 0, errors = 0, cyc = 0, op_edge = 0;

  wdog_keyed #(.BASE_EXP(2)) i_wdog_keyed (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_irq(wdt_irq), .wdt_rst_out(wdt_rst_out)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 100000", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_op(input logic w, input logic [4:0] a, input logic [31:0] d,
                        output logic [31:0] q);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    op_edge = cyc;
    q = bus_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus_op(1'b1, a, d, q);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] q);
    bus_op(1'b0, a, 32'h0, q);
  endtask

  task automatic wait_sig(input bit which_rst, output int at);
    at = -1;
    for (int i = 0; i < 4000; i++) begin
      if (which_rst ? wdt_rst_out : wdt_irq) begin
        at = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (wdt_rst_out && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] q;
    do_reset();
    rd(5'h00, q); chk("R1 ctrl", q, 0);
    rd(5'h04, q); chk("R1 range", q, 0);
    rd(5'h08, q); chk("R1 count", q, 0);
    rd(5'h10, q); chk("R1 status", q, 0);
    chk("R1 outputs", {wdt_irq, wdt_rst_out}, 0);
  endtask

  task automatic t_direct();
    logic [31:0] q; int e, at, n;
    do_reset();
    wr(5'h04, 32'h31);
    wr(5'h00, 32'h1); e = op_edge;
    rd(5'h08, q); chk("R3 init load", q, 31);
    rd(5'h08, q); chk("R4 decrement", q, 29);
    wait_sig(1'b1, at); chk("R6 reset edge", at - e, 33);
    chk("R6 no irq", wdt_irq, 0);
    pulse_len(n); chk("R8 width code 0", n, 2);
  endtask

  task automatic t_sticky();
    logic [31:0] q;
    do_reset();
    wr(5'h00, 32'h1D);
    wr(5'h00, 32'h00);
    rd(5'h00, q); chk("R2 enable sticky", q, 32'h1);
  endtask

  task automatic t_kick();
    logic [31:0] q; int e;
    do_reset();
    wr(5'h04, 32'h44);
    wr(5'h00, 32'h1); e = op_edge;
    wr(5'h0C, 32'h12);
    rd(5'h08, q); chk("R5 bad key ignored", q, 61);
    wr(5'h0C, 32'h176);
    rd(5'h08, q); chk("R5 key restart", q, 62);
    wr(5'h04, 32'h41);
    rd(5'h08, q); chk("R11 no mid-count change", q, 58);
    wr(5'h0C, 32'h76);
    rd(5'h08, q); chk("R11 new period on reload", q, 6);
    chk("R5 no pulse", wdt_rst_out, 0);
  endtask

  task automatic t_two_stage();
    logic [31:0] q; int e, at, n;
    do_reset();
    wr(5'h04, 32'h11);
    wr(5'h00, 32'h3); e = op_edge;
    wait_sig(1'b0, at); chk("R7 irq edge", at - e, 9);
    chk("R7 no reset at first expiry", wdt_rst_out, 0);
    wait_sig(1'b1, at); chk("R7 reset edge", at - e, 17);
    chk("R10 irq cleared at pulse", wdt_irq, 0);
    pulse_len(n); chk("R8 width two-stage", n, 2);
    rd(5'h08, q); chk("R10 reload after pulse", q, 7);
  endtask

  task automatic t_ack();
    logic [31:0] q; int e, at;
    do_reset();
    wr(5'h04, 32'h22);
    wr(5'h00, 32'h3); e = op_edge;
    wait_sig(1'b0, at); chk("R7 irq edge P16", at - e, 17);
    rd(5'h10, q); chk("R9 status set", q, 1);
    rd(5'h14, q); chk("R9 ack clears irq", wdt_irq, 0);
    rd(5'h08, q); chk("R9 count untouched", q, 10);
    rd(5'h10, q); chk("R9 status clear", q, 0);
    wait_sig(1'b0, at); chk("R7 irq again", at - e, 33);
    chk("R7 no reset after ack", wdt_rst_out, 0);
    wr(5'h0C, 32'h76);
    chk("R5 key clears irq", wdt_irq, 0);
    rd(5'h08, q); chk("R5 reload in two-stage", q, 14);
  endtask

  task automatic t_width(input int code);
    logic [31:0] q; int e, at, n;
    do_reset();
    wr(5'h04, 32'h00);
    wr(5'h00, 32'h1 | (code << 2)); e = op_edge;
    wait_sig(1'b1, at); chk("R6 reset edge P4", at - e, 5);
    pulse_len(n); chk("R8 pulse width", n, 2 << code);
    rd(5'h08, q); chk("R10 reload after pulse", q, 3);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_sticky();
    t_kick();
    t_two_stage();
    t_ack();
    t_width(0);
    t_width(3);
    t_width(7);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule